// File: doc/BRIEF.md
# DMA Channel Address, Count and Terminal-Count Unit

This block keeps the working state of four DMA channels: a 16-bit address pointer, a 14-bit remaining-count field, and the 2-bit cycle type that is loaded together with the count. A register interface writes whole 16-bit words into any channel. A sequencer names the active channel and strobes `xfer_done_i` once for each completed byte transfer. On that strobe the address of the active channel steps up by one and its count steps down by one. In the same cycle the unit reports whether this transfer was the last of the block, and whether it closed a 128-transfer segment.

Two mode inputs change what happens at terminal count. With stop-on-terminal-count set, the unit pulses a clear for that channel's enable bit, which lives in the mode logic. With the reload mode set, channel 2 reaching terminal count starts a single-cycle update. During that cycle `upd_o` is high, and at its end channel 3's address, count and cycle type are copied into channel 2. A transfer strobe aimed at channel 2 during the update has no effect.

Top module: `dma_count_unit`

## Requirements
- R1: A load with `ld_sel_i`=0 writes `ld_data_i` into the address of channel `ld_ch_i`. Each accepted transfer on a channel adds 1 to its address, modulo 2^16. Other channels do not change. `addr_o` shows the address of channel `act_ch_i`.
- R2: A load with `ld_sel_i`=1 writes a count word. Bits [13:0] are the count and bits [15:14] are the cycle type: 00 verify, 01 write, 10 read, 11 illegal. An accepted transfer subtracts 1 from the count, modulo 2^14, and keeps the type. `ctype_o` shows the type of the active channel.
- R3: The count is programmed as the byte total minus one. `tc_o` is high in the cycle of an accepted transfer whose channel count is 0. After that the count wraps to 3FFF and later transfers do not raise `tc_o`.
- R4: `mark_o` is high in the cycle of every 128th accepted transfer on a channel, counted from that channel's last count load or reload.
- R5: `en_clr_o[i]` is high only together with a terminal-count transfer on channel i while `tc_stop_i`=1. Channel 2 is excluded while `autoload_i`=1.
- R6: `tc_flags_o[i]` goes high after a terminal-count transfer on channel i. It stays high until a count load to channel i clears it.
- R7: With `autoload_i`=1, a terminal-count transfer on channel 2 raises `upd_o` for exactly the next cycle. At the end of that cycle, channel 2 takes the address, count and type that channel 3 held, and its 128-transfer segment restarts.
- R8: A `xfer_done_i` on channel 2 while `upd_o` is high is ignored. It gives no `tc_o`, `mark_o` or enable clear, and it does not change channel 2's state.
- R9: An address load and a transfer on the same channel in the same cycle leave the loaded value in the address.
- R10: After reset all addresses, counts, types, flags and `upd_o` are 0, and `tc_o`, `mark_o` and `en_clr_o` stay low while no transfer is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Register-interface write strobe |
| ld_ch_i | input | 2 | Channel written |
| ld_sel_i | input | 1 | 0 address word, 1 count word |
| ld_data_i | input | 16 | Word written |
| tc_stop_i | input | 1 | Stop-on-terminal-count mode |
| autoload_i | input | 1 | Reload channel 2 from channel 3 |
| act_ch_i | input | 2 | Active (granted) channel |
| xfer_done_i | input | 1 | One transfer on the active channel completes |
| addr_o | output | 16 | Address of the active channel |
| ctype_o | output | 2 | Cycle type of the active channel |
| tc_o | output | 1 | Terminal-count transfer |
| mark_o | output | 1 | 128th transfer of a segment |
| tc_flags_o | output | 4 | Sticky per-channel terminal-count flags |
| en_clr_o | output | 4 | Per-channel enable clear pulse |
| upd_o | output | 1 | Channel 2 reload in progress |

## Verification
The hardest state to reach is the update cycle with a colliding strobe. Channel 2 must first be run to its terminal count with reload set. Then, in the single cycle while `upd_o` is high, a further channel-2 strobe must arrive, and the next transfer must show channel 3's freshly loaded values. The stimulus loads channel 3 with distinctive values first. It then runs channel 2 through a two-byte block and strobes channel 2 again right away. `mark_o` needs 128 transfers on one channel, so channel 3 is driven 130 times, with a channel-1 transfer placed in the middle to show that segment counting is per channel.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  localparam int unsigned NCH_DEF  = 4;
  localparam int unsigned AW_DEF   = 16;
  localparam int unsigned CW_DEF   = 14;
  localparam int unsigned MARK_DEF = 128;

  typedef enum logic [1:0] {
    CT_VERIFY = 2'b00,
    CT_WRITE  = 2'b01,
    CT_READ   = 2'b10,
    CT_BAD    = 2'b11
  } ctype_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 14,
  parameter int unsigned MW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic [AW-1:0] ld_addr_val_i,
  input  logic [CW-1:0] ld_cnt_val_i,
  input  logic [1:0]    ld_type_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  logic [AW-1:0] rl_addr_i,
  input  logic [CW-1:0] rl_cnt_i,
  input  logic [1:0]    rl_type_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic [1:0]    type_o,
  output logic          zero_o,
  output logic          mark_o,
  output logic          flag_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    type_q;
  logic [MW-1:0] seg_q;
  logic          flag_q;

  assign zero_o = (cnt_q == '0);
  assign mark_o = &seg_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign type_o = type_q;
  assign flag_o = flag_q;

  // priority per register: load, reload, step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (ld_addr_i) begin
      addr_q <= ld_addr_val_i;
    end else if (reload_i) begin
      addr_q <= rl_addr_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else if (ld_cnt_i) begin
      cnt_q  <= ld_cnt_val_i;
      type_q <= ld_type_i;
    end else if (reload_i) begin
      cnt_q  <= rl_cnt_i;
      type_q <= rl_type_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  // segment counter wraps naturally at 2**MW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
    end else if (ld_cnt_i || reload_i) begin
      seg_q <= '0;
    end else if (step_i) begin
      seg_q <= seg_q + MW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (ld_cnt_i) begin
      flag_q <= 1'b0;
    end else if (step_i && zero_o) begin
      flag_q <= 1'b1;
    end
  end

  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !ld_addr_i && !reload_i |=> addr_q == $past(addr_q) + AW'(1));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !ld_cnt_i && !reload_i |=> cnt_q == $past(cnt_q) - CW'(1) && type_q == $past(type_q));

  p_seg_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt_i || reload_i |=> seg_q == '0);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !ld_cnt_i |=> flag_q);

  p_addr_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_addr_i |=> addr_q == $past(ld_addr_val_i));
endmodule

// File: rtl/dma_reload_ctl.sv
module dma_reload_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic upd_o
);
  logic upd_q;

  // start cannot repeat while busy: the destination's strobe is blocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= start_i;
  end

  assign upd_o = upd_q;

  p_upd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  p_upd_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> upd_q);
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
  import dma_cnt_pkg::*;
#(
  parameter int unsigned NCH        = NCH_DEF,
  parameter int unsigned AW         = AW_DEF,
  parameter int unsigned CW         = CW_DEF,
  parameter int unsigned MARK_LEN   = MARK_DEF,
  parameter int unsigned RELOAD_DST = 2,
  parameter int unsigned RELOAD_SRC = 3,
  localparam int unsigned CHW       = $clog2(NCH),
  localparam int unsigned MW        = $clog2(MARK_LEN),
  localparam int unsigned WW        = (AW > CW + 2) ? AW : CW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_we_i,
  input  logic [CHW-1:0] ld_ch_i,
  input  logic           ld_sel_i,
  input  logic [WW-1:0]  ld_data_i,
  input  logic           tc_stop_i,
  input  logic           autoload_i,
  input  logic [CHW-1:0] act_ch_i,
  input  logic           xfer_done_i,
  output logic [AW-1:0]  addr_o,
  output logic [1:0]     ctype_o,
  output logic           tc_o,
  output logic           mark_o,
  output logic [NCH-1:0] tc_flags_o,
  output logic [NCH-1:0] en_clr_o,
  output logic           upd_o
);
  logic [AW-1:0]  addr_v [NCH];
  logic [CW-1:0]  cnt_v  [NCH];
  logic [1:0]     type_v [NCH];
  logic [NCH-1:0] zero_v, mark_v, flag_v, step_v;
  logic           upd;
  logic           start;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit IS_DST = (i == RELOAD_DST);
    logic ld_a, ld_c;

    assign ld_a = ld_we_i && !ld_sel_i && (ld_ch_i == CHW'(i));
    assign ld_c = ld_we_i &&  ld_sel_i && (ld_ch_i == CHW'(i));
    // reload destination is frozen while its update runs
    assign step_v[i] = xfer_done_i && (act_ch_i == CHW'(i)) && !(IS_DST && upd);
    assign en_clr_o[i] = step_v[i] && zero_v[i] && tc_stop_i && !(IS_DST && autoload_i);

    dma_chan_regs #(.AW(AW), .CW(CW), .MW(MW)) i_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ld_addr_i     (ld_a),
      .ld_cnt_i      (ld_c),
      .ld_addr_val_i (ld_data_i[AW-1:0]),
      .ld_cnt_val_i  (ld_data_i[CW-1:0]),
      .ld_type_i     (ld_data_i[CW+1:CW]),
      .step_i        (step_v[i]),
      .reload_i      (IS_DST ? upd : 1'b0),
      .rl_addr_i     (addr_v[RELOAD_SRC]),
      .rl_cnt_i      (cnt_v[RELOAD_SRC]),
      .rl_type_i     (type_v[RELOAD_SRC]),
      .addr_o        (addr_v[i]),
      .cnt_o         (cnt_v[i]),
      .type_o        (type_v[i]),
      .zero_o        (zero_v[i]),
      .mark_o        (mark_v[i]),
      .flag_o        (flag_v[i])
    );
  end

  assign start = step_v[RELOAD_DST] && zero_v[RELOAD_DST] && autoload_i;

  dma_reload_ctl i_reload (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .upd_o   (upd)
  );

  assign addr_o     = addr_v[act_ch_i];
  assign ctype_o    = type_v[act_ch_i];
  assign tc_o       = |(step_v & zero_v);
  assign mark_o     = |(step_v & mark_v);
  assign tc_flags_o = flag_v;
  assign upd_o      = upd;

  p_en_clr_tc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_o != '0 |-> $onehot0(en_clr_o) && tc_o && tc_stop_i);

  p_reload_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && !(ld_we_i && ld_ch_i == CHW'(RELOAD_DST))
    |=> addr_v[RELOAD_DST] == $past(addr_v[RELOAD_SRC]) && cnt_v[RELOAD_DST] == $past(cnt_v[RELOAD_SRC]));

  p_ignore_dst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && xfer_done_i && act_ch_i == CHW'(RELOAD_DST) |-> !tc_o && !mark_o && en_clr_o == '0);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_done_i |-> !tc_o && !mark_o && en_clr_o == '0);
endmodule

// File: tb/test_dma_count_unit.sv
module test_dma_count_unit;
  localparam int CLK_P = 10;

  typedef struct {
    int         ch;
    logic [15:0] addr;
    logic [1:0]  ty;
    logic        tc, mark, upd;
    logic [3:0]  en, flags;
  } item_t;

  logic        clk = 0, rst_ni = 0;
  logic        ld_we = 0, ld_sel = 0, tc_stop = 0, autoload = 0, xfer_done = 0;
  logic [1:0]  ld_ch = 0, act_ch = 0;
  logic [15:0] ld_data = 0;
  logic [15:0] addr;
  logic [1:0]  ctype;
  logic        tc, mark, upd;
  logic [3:0]  tc_flags, en_clr;

  int checks = 0, errors = 0;
  item_t q[$];

  logic [15:0] m_addr [4];
  logic [13:0] m_cnt  [4];
  logic [1:0]  m_ty   [4];
  int          m_seg  [4];
  logic [3:0]  m_flag;
  logic        m_upd;

  always #(CLK_P/2) clk = ~clk;

  dma_count_unit i_dma_count_unit (
    .clk_i(clk), .rst_ni(rst_ni), .ld_we_i(ld_we), .ld_ch_i(ld_ch), .ld_sel_i(ld_sel),
    .ld_data_i(ld_data), .tc_stop_i(tc_stop), .autoload_i(autoload), .act_ch_i(act_ch),
    .xfer_done_i(xfer_done), .addr_o(addr), .ctype_o(ctype), .tc_o(tc), .mark_o(mark),
    .tc_flags_o(tc_flags), .en_clr_o(en_clr), .upd_o(upd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_reload();
    m_addr[2] = m_addr[3];
    m_cnt[2]  = m_cnt[3];
    m_ty[2]   = m_ty[3];
    m_seg[2]  = 0;
    m_upd     = 0;
  endtask

  task automatic load(input int ch, input bit sel, input logic [15:0] val);
    @(negedge clk);
    ld_we = 1; ld_ch = 2'(ch); ld_sel = sel; ld_data = val; xfer_done = 0;
    if (m_upd) apply_reload();
    if (sel) begin
      m_cnt[ch] = val[13:0]; m_ty[ch] = val[15:14]; m_seg[ch] = 0; m_flag[ch] = 1'b0;
    end else begin
      m_addr[ch] = val;
    end
  endtask

  // driver: one transfer strobe, optionally with an address load on the same channel
  task automatic xfer(input int ch, input bit ld_too = 0, input logic [15:0] val = 0);
    item_t it;
    logic cur_upd, ign, tcv, mk;
    logic [15:0] s_addr; logic [13:0] s_cnt; logic [1:0] s_ty;
    @(negedge clk);
    ld_we = ld_too; ld_ch = 2'(ch); ld_sel = 0; ld_data = val;
    act_ch = 2'(ch); xfer_done = 1;
    cur_upd = m_upd;
    ign = (ch == 2) && cur_upd;
    tcv = !ign && (m_cnt[ch] == 0);
    mk  = !ign && (m_seg[ch] == 127);
    it.ch = ch; it.addr = m_addr[ch]; it.ty = m_ty[ch]; it.upd = cur_upd; it.flags = m_flag;
    it.tc = tcv; it.mark = mk;
    it.en = (tcv && tc_stop && !(ch == 2 && autoload)) ? 4'(1 << ch) : 4'h0;
    q.push_back(it);
    s_addr = m_addr[3]; s_cnt = m_cnt[3]; s_ty = m_ty[3];
    if (!ign) begin
      m_addr[ch] = m_addr[ch] + 16'd1;
      m_cnt[ch]  = m_cnt[ch] - 14'd1;
      m_seg[ch]  = (m_seg[ch] + 1) % 128;
      if (tcv) m_flag[ch] = 1'b1;
    end
    if (ld_too) m_addr[ch] = val;
    if (cur_upd) begin
      m_addr[2] = s_addr; m_cnt[2] = s_cnt; m_ty[2] = s_ty; m_seg[2] = 0;
    end
    m_upd = (ch == 2) && tcv && autoload;
  endtask

  task automatic idle(input int ch, input string req);
    @(negedge clk);
    ld_we = 0; xfer_done = 0; act_ch = 2'(ch);
    #(CLK_P/4);
    chk({req, " upd"}, upd, m_upd);
    chk({req, " addr"}, addr, m_addr[ch]);
    chk({req, " ctype"}, ctype, m_ty[ch]);
    chk({req, " flags"}, tc_flags, m_flag);
    chk({req, " quiet"}, {tc, mark, en_clr}, 6'h0);
    if (m_upd) apply_reload();
  endtask

  // monitor: pops one expected item per strobe
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (xfer_done) begin
      if (q.size() == 0) begin
        chk("R1 queue", 0, 1);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.upd && it.ch == 2) begin
          chk("R8 tc", tc, 0); chk("R8 mark", mark, 0); chk("R8 en_clr", en_clr, 0);
        end else begin
          chk("R3 tc", tc, it.tc); chk("R4 mark", mark, it.mark); chk("R5 en_clr", en_clr, it.en);
        end
        chk("R1 addr", addr, it.addr);
        chk("R2 ctype", ctype, it.ty);
        chk("R6 flags", tc_flags, it.flags);
        chk("R7 upd", upd, it.upd);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_cnt[i] = 0; m_ty[i] = 0; m_seg[i] = 0;
    end
    m_flag = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R10 reset state
    for (int c = 0; c < 4; c++) idle(c, "R10");

    // R1 R2 R3 R5: four-byte write block with stop on terminal count
    tc_stop = 1;
    load(0, 0, 16'h1000);
    load(0, 1, {2'b01, 14'd3});
    for (int i = 0; i < 5; i++) xfer(0);   // 5th shows wrapped count, no tc

    // R1 address wrap, stop off: no enable clear
    tc_stop = 0;
    load(1, 0, 16'hFFFE);
    load(1, 1, {2'b10, 14'd1});
    xfer(1); xfer(1);
    idle(1, "R3");

    // R4 segment mark after 128 transfers, per channel
    load(3, 0, 16'h2000);
    load(3, 1, {2'b00, 14'd299});
    for (int i = 0; i < 130; i++) begin
      if (i == 64) xfer(1);
      xfer(3);
    end
    idle(3, "R4");

    // R6 flag cleared by count load
    load(0, 1, {2'b11, 14'd7});
    idle(0, "R6");

    // R7 R8 reload of channel 2 from channel 3
    tc_stop = 1; autoload = 1;
    load(3, 0, 16'h4000);
    load(3, 1, {2'b10, 14'd5});
    load(2, 0, 16'h3000);
    load(2, 1, {2'b01, 14'd1});
    xfer(2); xfer(2);        // tc on 2nd, no enable clear for channel 2
    xfer(2);                 // lands in update cycle: ignored
    xfer(2);                 // first transfer of reloaded block
    idle(2, "R7");
    xfer(3);
    // R7 idle path through the update cycle
    load(2, 1, {2'b00, 14'd0});
    xfer(2);
    idle(2, "R7");
    idle(2, "R7");

    // R9 address load wins over a same-cycle transfer
    autoload = 0;
    xfer(1, 1, 16'h5555);
    idle(1, "R9");
    xfer(1);
    idle(1, "R9");

    chk("R1 queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule